// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits on the host side of a three-wire serial digital-to-analog converter link and turns parallel 12-bit two's-complement samples into 16-bit serial frames. A producer offers a sample with a valid/ready handshake. The controller zero-extends the sample to 16 bits and pulls the active-low frame select. It then produces sixteen serial clock cycles, most significant bit first. Data changes only on rising clock edges, so the converter sees stable data at every falling edge.

After the sixteenth cycle, the controller keeps the frame select low for one more system clock and then releases it. In manual mode it then drives the active-low load strobe low for a fixed number of system clocks, which moves the frame into the converter's output latch. In auto-load mode the converter updates by itself once sixteen bits have arrived, so the strobe phase is skipped and the controller becomes ready again as soon as the frame select rises. The serial clock half period and the strobe width are counted in system clocks and set by parameters. The defaults give a 200 ns serial clock with a 50% duty cycle and a 20 ns strobe on a 100 MHz system clock.

Top module: `dac_serial_writer`

## Requirements
- R1: Each frame is 16 bits sent most significant bit first: frame bits 15..12 are zero and bits 11..0 are the accepted sample, unchanged.
- R2: Frame select falls in the cycle after a sample is accepted (s_valid and s_ready both high at a rising clk edge), with the serial clock high; the first serial clock fall comes HALF_DIV system clocks after the frame select falls.
- R3: Within a frame, every high phase and every low phase of the serial clock lasts exactly HALF_DIV system clocks, giving a 50% duty cycle and a period of 2*HALF_DIV clocks.
- R4: While frame select is low, serial data changes only together with a rising serial clock edge, and it never changes at a falling edge.
- R5: Every frame has exactly 16 falling serial clock edges. The serial clock idles high whenever frame select is high. Frame select stays low for 32*HALF_DIV+1 system clocks, which is one clock beyond the last rising edge.
- R6: In manual mode (auto_load low at acceptance) the load strobe falls in the same cycle that frame select rises and stays low for exactly LOAD_CYC system clocks. It is never low while frame select is low.
- R7: In auto-load mode (auto_load high at acceptance) no load strobe pulse is issued, and s_ready returns in the cycle frame select rises, after 32*HALF_DIV+1 cycles low.
- R8: s_ready is low from acceptance until the load phase ends (32*HALF_DIV+1+LOAD_CYC cycles in manual mode). Changes to s_sample or auto_load after acceptance have no effect on the frame in progress. A request held pending is accepted in the first cycle s_ready is high. With s_valid low, no frame starts.
- R9: After reset the outputs are frame select high, serial clock high, load strobe high, serial data low and s_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Controller can accept a sample |
| s_sample | input | 12 | Two's-complement sample |
| auto_load | input | 1 | 1: skip the load strobe phase for this frame |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_sdata | output | 1 | Serial data, MSB first |
| dac_load_n | output | 1 | Active-low load strobe |

## Verification
Two events share a clock edge. When frame select is released, the load strobe begins in manual mode, or s_ready returns in auto-load mode. The bench provokes both cases, including one with a second request already held on s_valid. It judges them by sampling between edges: the strobe must fall in the same sample in which frame select is first seen high. In the held-request case, s_ready must be seen high for exactly one sample before the next frame select falls.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_SHIFT = 2'd1,
    WR_HOLD  = 2'd2,
    WR_LOAD  = 2'd3
  } wr_state_e;
endpackage

// File: rtl/dacw_half_timer.sv
module dacw_half_timer #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counter advances only while a frame is shifting; otherwise it is parked at zero.
  always_comb begin
    cnt_en = run || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/dacw_frame_shifter.sv
module dacw_frame_shifter #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sr_en;

  // Zero-extension pads the upper frame bits; data leaves from the top.
  always_comb begin
    sr_en = load || shift;
    sr_d  = sr_q;
    if (load)       sr_d = FRAME_W'(din);
    else if (shift) sr_d = {sr_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign msb = sr_q[FRAME_W-1];

  assert_no_load_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/dacw_sequencer.sv
module dacw_sequencer
  import dacw_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int LOAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_auto,
  input  logic tick,
  output logic req_ready,
  output logic run,
  output logic load,
  output logic shift,
  output logic sclk,
  output logic sync_n,
  output logic load_n
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam int LW = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W);
  localparam logic [LW-1:0] LD_LAST  = LW'(LOAD_CYC - 1);

  wr_state_e     st_q, st_d;
  logic          sclk_q, sclk_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          auto_q, auto_d;
  logic [LW-1:0] ld_q, ld_d;

  always_comb begin
    st_d   = st_q;
    sclk_d = sclk_q;
    bit_d  = bit_q;
    auto_d = auto_q;
    ld_d   = ld_q;
    load   = 1'b0;
    shift  = 1'b0;
    unique case (st_q)
      WR_IDLE: begin
        if (req_valid) begin
          load   = 1'b1;
          st_d   = WR_SHIFT;
          auto_d = req_auto;
          bit_d  = '0;
          sclk_d = 1'b1;
        end
      end
      WR_SHIFT: begin
        if (tick) begin
          sclk_d = ~sclk_q;
          if (sclk_q) begin
            bit_d = bit_q + 1'b1;
          end else if (bit_q == LAST_BIT) begin
            st_d = WR_HOLD;
          end else begin
            shift = 1'b1;
          end
        end
      end
      WR_HOLD: begin
        ld_d = '0;
        st_d = auto_q ? WR_IDLE : WR_LOAD;
      end
      WR_LOAD: begin
        ld_d = ld_q + 1'b1;
        if (ld_q == LD_LAST) st_d = WR_IDLE;
      end
      default: st_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      sclk_q <= 1'b1;
      bit_q  <= '0;
      auto_q <= 1'b0;
      ld_q   <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      auto_q <= auto_d;
      ld_q   <= ld_d;
    end
  end

  assign req_ready = (st_q == WR_IDLE);
  assign run       = (st_q == WR_SHIFT);
  assign sclk      = sclk_q;
  assign sync_n    = !((st_q == WR_SHIFT) || (st_q == WR_HOLD));
  assign load_n    = (st_q != WR_LOAD);

  assert_sync_fall_sclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> sclk);
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> sync_n);
  assert_auto_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WR_HOLD && auto_q) |=> load_n);
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int SAMPLE_W = 12,
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 10,
  parameter int LOAD_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic                auto_load,
  output logic                dac_sclk,
  output logic                dac_sync_n,
  output logic                dac_sdata,
  output logic                dac_load_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       tick, run, load, shift;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  dacw_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick)
  );

  dacw_frame_shifter #(.DATA_W(SAMPLE_W), .FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(load), .shift(shift),
    .din(s_sample), .msb(dac_sdata)
  );

  dacw_sequencer #(.FRAME_W(FRAME_W), .LOAD_CYC(LOAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .req_valid(s_valid), .req_auto(auto_load),
    .tick(tick), .req_ready(s_ready), .run(run), .load(load), .shift(shift),
    .sclk(dac_sclk), .sync_n(dac_sync_n), .load_n(dac_load_n)
  );

  assert_sdata_stable_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(dac_sclk) |-> $stable(dac_sdata));
endmodule

// File: tb/tb_dac_serial_writer.sv
module tb_dac_serial_writer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 10;
  localparam int LOAD_CYC   = 2;
  localparam int SYNC_LOW   = 32 * HALF_DIV + 1;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_sample = '0;
  logic        auto_load = 1'b0;
  logic        dac_sclk, dac_sync_n, dac_sdata, dac_load_n;

  int tests_run = 0;
  int tests_failed = 0;
  int cyc = 0;

  dac_serial_writer #(.SAMPLE_W(12), .FRAME_W(16), .HALF_DIV(HALF_DIV), .LOAD_CYC(LOAD_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .auto_load(auto_load), .dac_sclk(dac_sclk),
    .dac_sync_n(dac_sync_n), .dac_sdata(dac_sdata), .dac_load_n(dac_load_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Converter-side monitor, sampled between rising edges.
  logic        p_sclk = 1'b1, p_sync = 1'b1, p_sdata = 1'b0, p_load = 1'b1, p_ready = 1'b1;
  logic [15:0] cur_word;
  logic [15:0] words [0:3];
  int cur_bits, frames, bits_last, run_len, first_run, phase_bad, data_bad;
  int sync_run, sync_last, ld_run, ld_last, ld_pulses, ld_overlap, ld_aligned;
  int rdy_low_run, rdy_low_last, rdy_hi_run, rdy_hi_last;

  task automatic clear_mon();
    cur_word = '0; cur_bits = 0; frames = 0; bits_last = 0; run_len = 0;
    first_run = 0; phase_bad = 0; data_bad = 0; sync_run = 0; sync_last = 0;
    ld_run = 0; ld_last = 0; ld_pulses = 0; ld_overlap = 0; ld_aligned = 0;
    rdy_low_run = 0; rdy_low_last = 0; rdy_hi_run = 0; rdy_hi_last = 0;
    for (int i = 0; i < 4; i++) words[i] = '0;
  endtask

  initial clear_mon();

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (p_sync && !dac_sync_n) begin
        cur_word = '0; cur_bits = 0; run_len = 1; sync_run = 1;
      end else if (!dac_sync_n) begin
        sync_run++;
        if (dac_sclk != p_sclk) begin
          if (run_len != HALF_DIV) phase_bad++;
          if (p_sclk && !dac_sclk) begin
            if (cur_bits == 0) first_run = run_len;
            cur_word = {cur_word[14:0], dac_sdata};
            cur_bits++;
          end
          run_len = 1;
        end else begin
          run_len++;
        end
        if (dac_sdata != p_sdata && !p_sync && !(dac_sclk && !p_sclk)) data_bad++;
      end
      if (!p_sync && dac_sync_n) begin
        if (frames < 4) words[frames] = cur_word;
        frames++; bits_last = cur_bits; sync_last = sync_run;
      end
      if (dac_sync_n && !dac_sclk) phase_bad++;
      if (!dac_load_n) begin
        if (p_load) begin
          ld_pulses++; ld_run = 1;
          if (dac_sync_n && !p_sync) ld_aligned++;
        end else ld_run++;
        if (!dac_sync_n) ld_overlap++;
      end else if (!p_load) ld_last = ld_run;
      if (!s_ready) begin
        if (p_ready) begin rdy_hi_last = rdy_hi_run; rdy_low_run = 1; end
        else rdy_low_run++;
      end else begin
        if (!p_ready) begin rdy_low_last = rdy_low_run; rdy_hi_run = 1; end
        else rdy_hi_run++;
      end
    end
    p_sclk = dac_sclk; p_sync = dac_sync_n; p_sdata = dac_sdata;
    p_load = dac_load_n; p_ready = s_ready;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic fresh();
    @(posedge clk); clear_mon();
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(s_ready && dac_sync_n && dac_load_n)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Offer a sample, wait for acceptance, then scramble the inputs.
  task automatic send(input logic [11:0] v, input logic a);
    @(negedge clk);
    s_valid = 1'b1; s_sample = v; auto_load = a;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_sample = ~v; auto_load = ~a;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(dac_sync_n == 1'b1, "R9", "sync_n after reset", int'(dac_sync_n), 1);
    chk(dac_sclk == 1'b1, "R9", "sclk after reset", int'(dac_sclk), 1);
    chk(dac_load_n == 1'b1, "R9", "load_n after reset", int'(dac_load_n), 1);
    chk(dac_sdata == 1'b0, "R9", "sdata after reset", int'(dac_sdata), 0);
    chk(s_ready == 1'b1, "R9", "ready after reset", int'(s_ready), 1);
  endtask

  task automatic test_manual(input logic [11:0] v);
    fresh();
    send(v, 1'b0);
    wait_idle();
    chk(frames == 1, "R5", "frame count", frames, 1);
    chk(words[0] == {4'b0000, v}, "R1", "frame word", int'(words[0]), int'({4'b0000, v}));
    chk(bits_last == 16, "R5", "falling edges", bits_last, 16);
    chk(sync_last == SYNC_LOW, "R5", "sync low cycles", sync_last, SYNC_LOW);
    chk(first_run == HALF_DIV, "R2", "sync fall to first sclk fall", first_run, HALF_DIV);
    chk(phase_bad == 0, "R3", "bad sclk phases", phase_bad, 0);
    chk(data_bad == 0, "R4", "sdata changes off rising edge", data_bad, 0);
    chk(ld_pulses == 1, "R6", "strobe pulses", ld_pulses, 1);
    chk(ld_last == LOAD_CYC, "R6", "strobe width", ld_last, LOAD_CYC);
    chk(ld_aligned == 1, "R6", "strobe falls with sync rise", ld_aligned, 1);
    chk(ld_overlap == 0, "R6", "strobe low under sync low", ld_overlap, 0);
    chk(rdy_low_last == SYNC_LOW + LOAD_CYC, "R8", "ready low cycles", rdy_low_last, SYNC_LOW + LOAD_CYC);
  endtask

  task automatic test_auto(input logic [11:0] v);
    fresh();
    send(v, 1'b1);
    wait_idle();
    chk(words[0] == {4'b0000, v}, "R1", "auto frame word", int'(words[0]), int'({4'b0000, v}));
    chk(bits_last == 16, "R5", "auto falling edges", bits_last, 16);
    chk(ld_pulses == 0, "R7", "auto strobe pulses", ld_pulses, 0);
    chk(rdy_low_last == SYNC_LOW, "R7", "auto ready low cycles", rdy_low_last, SYNC_LOW);
    chk(phase_bad == 0 && data_bad == 0, "R3", "auto clock/data shape", phase_bad + data_bad, 0);
  endtask

  // Second request held on s_valid while the first frame runs.
  task automatic test_back_to_back(input logic [11:0] v1, input logic [11:0] v2, input logic a1);
    fresh();
    send(v1, a1);
    s_valid = 1'b1; s_sample = v2; auto_load = 1'b0;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_sample = 12'h000;
    wait_idle();
    chk(frames == 2, "R8", "held request frames", frames, 2);
    chk(words[0] == {4'b0000, v1}, "R1", "first word", int'(words[0]), int'({4'b0000, v1}));
    chk(words[1] == {4'b0000, v2}, "R8", "held word", int'(words[1]), int'({4'b0000, v2}));
    chk(rdy_hi_last == 1, "R8", "ready high samples between frames", rdy_hi_last, 1);
    chk(ld_pulses == (a1 ? 1 : 2), "R6", "strobe pulses in pair", ld_pulses, a1 ? 1 : 2);
    chk(ld_overlap == 0, "R6", "strobe overlap in pair", ld_overlap, 0);
  endtask

  task automatic test_no_valid();
    fresh();
    s_valid = 1'b0; s_sample = 12'hFFF; auto_load = 1'b0;
    repeat (40) @(negedge clk);
    chk(frames == 0 && dac_sync_n, "R8", "frames without valid", frames, 0);
    chk(ld_pulses == 0, "R8", "strobes without valid", ld_pulses, 0);
  endtask

  always @(negedge clk) begin
    if (cyc > WATCHDOG) begin
      tests_run++; tests_failed++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_manual(12'h7FF);
    test_manual(12'h800);
    test_manual(12'h5A3);
    test_auto(12'hA5A);
    test_auto(12'h001);
    test_back_to_back(12'h123, 12'hFFF, 1'b0);
    test_back_to_back(12'h3C0, 12'h00F, 1'b1);
    test_no_valid();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule